// File: doc/BRIEF.md
# Beam-Position Debug State Capture

This block takes a one-shot snapshot of a set of internal video-pipeline signals at a screen coordinate chosen by software. Software writes a target column and row, arms the unit, and waits at least one frame. It then reads the frozen probe values back through a small register port. When the beam counters match the programmed point on a clock where the pixel strobe is high, every probe lane is latched at once and a valid flag is raised.

While the unit is armed, it also draws a red crosshair through the target point. This shows the probed location on the display. The pixel colour path carries one register stage. This keeps the compare-and-mux logic off the critical path of the pixel clock.

Probe values and colours stream through every cycle with no back-pressure. The pixel strobe `pix_en` only qualifies which clocks count as pixels. The register port is plain: writes take effect at the clock edge, and reads are combinational.

Top module: `beam_probe_capture`

## Requirements
- R1: After reset, both targets read 0, the unit is disarmed, the valid flag (bit 0 of address 3) is 0, every snapshot lane reads 0, and `rgb_out` and `mark_out` are 0.
- R2: A write to address 0 sets the target column and a write to address 1 sets the target row. A read of either address returns the stored value, zero-extended.
- R3: Bit 0 of address 2 is the arm bit. Writing 1 arms the unit, writing 0 disarms it, and reading address 2 returns the bit.
- R4: On a clock where the unit is armed, `pix_en` is 1, `beam_x` equals the target column and `beam_y` equals the target row, every probe lane is latched. Lane i (bits i*16 upward of `probe_bus`) then reads at address 4+i from the next cycle, and the valid flag becomes 1.
- R5: No capture happens while disarmed, while `pix_en` is 0, or when only one of the two coordinates matches. In each of these cases the snapshot lanes keep their values.
- R6: A snapshot stays readable until a later capture replaces it. Writing a new target clears the valid flag but leaves the lanes unchanged.
- R7: A write to address 0 or 1 clears the valid flag, even if a capture happens on the same clock. The lanes still take that capture.
- R8: One cycle after a clock where the unit is armed, `pix_en` is 1, and `beam_x` equals the target column or `beam_y` equals the target row, `rgb_out` is 12'hF00 and `mark_out` is 1. On every other clock, `rgb_out` is the `rgb_in` of the previous cycle and `mark_out` is 0.
- R9: A read of address 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Marks clocks that carry a pixel |
| beam_x | input | 12 | Current beam column |
| beam_y | input | 12 | Current beam row |
| probe_bus | input | 48 | Probed signals, three 16-bit lanes |
| rgb_in | input | 12 | Pixel colour from the pipeline |
| rgb_out | output | 12 | Pixel colour after the crosshair overlay |
| mark_out | output | 1 | High where the crosshair overrides the colour |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 16 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 16 | Register read data |

## Verification
The assertions watch several rules on every cycle:
- the valid flag rises after each qualifying coordinate match;
- a target write always clears the flag;
- the lanes never change without a capture;
- a marked pixel always carries the marker colour;
- a disarmed unit never marks.

Other behaviours can only be shown by the bench's scenarios:
- that the lane values read back are the probe words present on the matching clock;
- that a snapshot survives later frames and target rewrites;
- that the crosshair hits exactly the target row and column and passes all other colours through unchanged.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int REG_AW = 3;
  localparam int REG_DW = 16;
  localparam logic [REG_AW-1:0] ADDR_TGT_X = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_TGT_Y = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_CTRL  = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_STAT  = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_LANE0 = 3'd4;
endpackage

// File: rtl/bpc_regfile.sv
module bpc_regfile
  import bpc_pkg::*;
#(
  parameter int X_W = 12,
  parameter int Y_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              cap_fire,
  output logic [X_W-1:0]    tgt_x,
  output logic [Y_W-1:0]    tgt_y,
  output logic              armed,
  output logic              valid
);
  logic tgt_write;
  assign tgt_write = we && (waddr == ADDR_TGT_X || waddr == ADDR_TGT_Y);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_x <= '0;
      tgt_y <= '0;
      armed <= 1'b0;
      valid <= 1'b0;
    end else begin
      if (we && waddr == ADDR_TGT_X) tgt_x <= wdata[X_W-1:0];
      if (we && waddr == ADDR_TGT_Y) tgt_y <= wdata[Y_W-1:0];
      if (we && waddr == ADDR_CTRL)  armed <= wdata[0];
      // a target write outranks a capture on the same edge
      if (tgt_write)     valid <= 1'b0;
      else if (cap_fire) valid <= 1'b1;
    end
  end
endmodule

// File: rtl/bpc_trigger.sv
module bpc_trigger #(
  parameter int X_W = 12,
  parameter int Y_W = 12
) (
  input  logic           pix_en,
  input  logic           armed,
  input  logic [X_W-1:0] beam_x,
  input  logic [Y_W-1:0] beam_y,
  input  logic [X_W-1:0] tgt_x,
  input  logic [Y_W-1:0] tgt_y,
  output logic           cap_fire,
  output logic           cross_hit
);
  logic col_hit, row_hit, live;
  always_comb begin
    col_hit   = (beam_x == tgt_x);
    row_hit   = (beam_y == tgt_y);
    live      = armed && pix_en;
    cap_fire  = live && col_hit && row_hit;
    cross_hit = live && (col_hit || row_hit);
  end
endmodule

// File: rtl/bpc_snapshot.sv
module bpc_snapshot #(
  parameter int LANES  = 3,
  parameter int LANE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_fire,
  input  logic [LANES*LANE_W-1:0] probe_bus,
  output logic [LANES*LANE_W-1:0] snap_flat
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)        snap_flat[g*LANE_W +: LANE_W] <= '0;
      else if (cap_fire) snap_flat[g*LANE_W +: LANE_W] <= probe_bus[g*LANE_W +: LANE_W];
    end
  end
endmodule

// File: rtl/bpc_overlay.sv
module bpc_overlay #(
  parameter int              COL_W     = 12,
  parameter logic [COL_W-1:0] MARK_COL = 12'hF00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cross_hit,
  input  logic [COL_W-1:0] rgb_in,
  output logic [COL_W-1:0] rgb_out,
  output logic             mark_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgb_out  <= '0;
      mark_out <= 1'b0;
    end else begin
      rgb_out  <= cross_hit ? MARK_COL : rgb_in;
      mark_out <= cross_hit;
    end
  end
endmodule

// File: rtl/beam_probe_capture.sv
module beam_probe_capture
  import bpc_pkg::*;
#(
  parameter int               X_W      = 12,
  parameter int               Y_W      = 12,
  parameter int               LANES    = 3,
  parameter int               LANE_W   = 16,
  parameter int               COL_W    = 12,
  parameter logic [COL_W-1:0] MARK_COL = 12'hF00
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pix_en,
  input  logic [X_W-1:0]          beam_x,
  input  logic [Y_W-1:0]          beam_y,
  input  logic [LANES*LANE_W-1:0] probe_bus,
  input  logic [COL_W-1:0]        rgb_in,
  output logic [COL_W-1:0]        rgb_out,
  output logic                    mark_out,
  input  logic                    reg_we,
  input  logic [REG_AW-1:0]       reg_waddr,
  input  logic [REG_DW-1:0]       reg_wdata,
  input  logic [REG_AW-1:0]       reg_raddr,
  output logic [REG_DW-1:0]       reg_rdata
);
  localparam int LANE_BASE = int'(ADDR_LANE0);

  logic [X_W-1:0]          tgt_x;
  logic [Y_W-1:0]          tgt_y;
  logic                    armed, valid, cap_fire, cross_hit;
  logic [LANES*LANE_W-1:0] snap_flat;

  bpc_regfile #(.X_W(X_W), .Y_W(Y_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .cap_fire(cap_fire), .tgt_x(tgt_x), .tgt_y(tgt_y), .armed(armed), .valid(valid)
  );

  bpc_trigger #(.X_W(X_W), .Y_W(Y_W)) i_trig (
    .pix_en(pix_en), .armed(armed), .beam_x(beam_x), .beam_y(beam_y),
    .tgt_x(tgt_x), .tgt_y(tgt_y), .cap_fire(cap_fire), .cross_hit(cross_hit)
  );

  bpc_snapshot #(.LANES(LANES), .LANE_W(LANE_W)) i_snap (
    .clk(clk), .rst_n(rst_n), .cap_fire(cap_fire), .probe_bus(probe_bus),
    .snap_flat(snap_flat)
  );

  bpc_overlay #(.COL_W(COL_W), .MARK_COL(MARK_COL)) i_ovl (
    .clk(clk), .rst_n(rst_n), .cross_hit(cross_hit), .rgb_in(rgb_in),
    .rgb_out(rgb_out), .mark_out(mark_out)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      ADDR_TGT_X: reg_rdata = REG_DW'(tgt_x);
      ADDR_TGT_Y: reg_rdata = REG_DW'(tgt_y);
      ADDR_CTRL:  reg_rdata = REG_DW'(armed);
      ADDR_STAT:  reg_rdata = REG_DW'(valid);
      default: begin
        for (int i = 0; i < LANES; i++)
          if (int'(reg_raddr) == LANE_BASE + i)
            reg_rdata = REG_DW'(snap_flat[i*LANE_W +: LANE_W]);
      end
    endcase
  end
endmodule

// File: rtl/beam_probe_capture_chk.sv
module beam_probe_capture_chk
  import bpc_pkg::*;
#(
  parameter int               X_W      = 12,
  parameter int               Y_W      = 12,
  parameter int               LANES    = 3,
  parameter int               LANE_W   = 16,
  parameter int               COL_W    = 12,
  parameter logic [COL_W-1:0] MARK_COL = 12'hF00
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pix_en,
  input logic [X_W-1:0]          beam_x,
  input logic [Y_W-1:0]          beam_y,
  input logic                    reg_we,
  input logic [REG_AW-1:0]       reg_waddr,
  input logic [X_W-1:0]          tgt_x,
  input logic [Y_W-1:0]          tgt_y,
  input logic                    armed,
  input logic                    valid,
  input logic [LANES*LANE_W-1:0] snap_flat,
  input logic [COL_W-1:0]        rgb_out,
  input logic                    mark_out
);
  logic tw, hit;
  assign tw  = reg_we && (reg_waddr == ADDR_TGT_X || reg_waddr == ADDR_TGT_Y);
  assign hit = armed && pix_en && beam_x == tgt_x && beam_y == tgt_y;

  a_r4_valid_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !tw) |=> valid);
  a_r7_target_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tw |=> !valid);
  a_r5_lanes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(snap_flat));
  a_r8_mark_colour: assert property (@(posedge clk) disable iff (!rst_n)
    mark_out |-> rgb_out == MARK_COL);
  a_r8_disarmed_no_mark: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !mark_out);
endmodule

bind beam_probe_capture beam_probe_capture_chk #(
  .X_W(X_W), .Y_W(Y_W), .LANES(LANES), .LANE_W(LANE_W), .COL_W(COL_W), .MARK_COL(MARK_COL)
) i_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .beam_x(beam_x), .beam_y(beam_y),
  .reg_we(reg_we), .reg_waddr(reg_waddr), .tgt_x(tgt_x), .tgt_y(tgt_y),
  .armed(armed), .valid(valid), .snap_flat(snap_flat), .rgb_out(rgb_out), .mark_out(mark_out)
);

// File: tb/test_beam_probe_capture.sv
module test_beam_probe_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0;
  logic [11:0] beam_x = '0, beam_y = '0;
  logic [47:0] probe_bus = '0;
  logic [11:0] rgb_in = '0;
  logic [11:0] rgb_out;
  logic        mark_out;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0, reg_raddr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  beam_probe_capture i_beam_probe_capture (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .beam_x(beam_x), .beam_y(beam_y),
    .probe_bus(probe_bus), .rgb_in(rgb_in), .rgb_out(rgb_out), .mark_out(mark_out),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata)
  );

  // {x, y, rgb_in, expected rgb_out, expected mark} with target (5,3) armed
  localparam logic [48:0] VEC [0:5] = '{
    {12'd5, 12'd9, 12'h123, 12'hF00, 1'b1},
    {12'd2, 12'd3, 12'h456, 12'hF00, 1'b1},
    {12'd5, 12'd3, 12'h0AB, 12'hF00, 1'b1},
    {12'd2, 12'd9, 12'h456, 12'h456, 1'b0},
    {12'd6, 12'd4, 12'h789, 12'h789, 1'b0},
    {12'd4, 12'd2, 12'hFFF, 12'hFFF, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_raddr = a;
    #1 d = reg_rdata;
  endtask

  // one pixel clock; leaves pix_en low and the registered output visible
  task automatic pix(logic [11:0] x, logic [11:0] y, logic en, logic [47:0] pr, logic [11:0] c);
    @(negedge clk);
    beam_x = x; beam_y = y; pix_en = en; probe_bus = pr; rgb_in = c;
    @(negedge clk);
    pix_en = 1'b0; beam_x = 12'd900; beam_y = 12'd900;
  endtask

  task automatic lanes(string req, logic [47:0] exp);
    logic [15:0] v;
    for (int i = 0; i < 3; i++) begin
      rd(3'(4 + i), v);
      check(req, {16'd0, v}, {16'd0, exp[i*16 +: 16]});
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, v); check("R1 tgt_x", v, 0);
    rd(3'd1, v); check("R1 tgt_y", v, 0);
    rd(3'd2, v); check("R1 arm", v, 0);
    rd(3'd3, v); check("R1 valid", v, 0);
    lanes("R1 lanes", 48'd0);
    check("R1 rgb_out", rgb_out, 0);
    check("R1 mark_out", mark_out, 0);
    // R2, R3 programming
    wr(3'd0, 16'd5); wr(3'd1, 16'd3); wr(3'd2, 16'd1);
    rd(3'd0, v); check("R2 tgt_x", v, 5);
    rd(3'd1, v); check("R2 tgt_y", v, 3);
    rd(3'd2, v); check("R3 arm", v, 1);
    // R4 capture
    pix(12'd5, 12'd3, 1'b1, 48'hAAAA_BBBB_CCCC, 12'h000);
    pix(12'd6, 12'd3, 1'b1, 48'h1111_2222_3333, 12'h000);
    rd(3'd3, v); check("R4 valid", v, 1);
    lanes("R4 lanes", 48'hAAAA_BBBB_CCCC);
    // R5 no capture cases
    pix(12'd5, 12'd4, 1'b1, 48'h0101_0101_0101, 12'h000);
    pix(12'd4, 12'd3, 1'b1, 48'h0202_0202_0202, 12'h000);
    pix(12'd5, 12'd3, 1'b0, 48'h0303_0303_0303, 12'h000);
    lanes("R5 partial/strobe", 48'hAAAA_BBBB_CCCC);
    wr(3'd2, 16'd0);
    rd(3'd2, v); check("R3 disarm", v, 0);
    pix(12'd5, 12'd3, 1'b1, 48'h0404_0404_0404, 12'h5A5);
    check("R8 disarmed rgb", rgb_out, 12'h5A5);
    check("R8 disarmed mark", mark_out, 0);
    lanes("R5 disarmed", 48'hAAAA_BBBB_CCCC);
    // R6 recapture overwrites
    wr(3'd2, 16'd1);
    pix(12'd5, 12'd3, 1'b1, 48'hDEAD_BEEF_CAFE, 12'h000);
    lanes("R6 overwrite", 48'hDEAD_BEEF_CAFE);
    // R7 target write clears valid, lanes kept
    wr(3'd1, 16'd3);
    rd(3'd3, v); check("R7 valid cleared", v, 0);
    lanes("R6 retained", 48'hDEAD_BEEF_CAFE);
    // R7 same-clock write and capture
    @(negedge clk);
    beam_x = 12'd5; beam_y = 12'd3; pix_en = 1'b1; probe_bus = 48'h7777_8888_9999;
    reg_we = 1'b1; reg_waddr = 3'd0; reg_wdata = 16'd5;
    @(negedge clk);
    reg_we = 1'b0; pix_en = 1'b0; beam_x = 12'd900; beam_y = 12'd900;
    rd(3'd3, v); check("R7 write beats capture", v, 0);
    lanes("R7 lanes captured", 48'h7777_8888_9999);
    // R8 crosshair table
    for (int k = 0; k < 6; k++) begin
      pix(VEC[k][48:37], VEC[k][36:25], 1'b1, 48'h0, VEC[k][24:13]);
      check("R8 rgb", rgb_out, VEC[k][12:1]);
      check("R8 mark", mark_out, VEC[k][0]);
    end
    pix(12'd5, 12'd3, 1'b0, 48'h0, 12'h3C3);
    check("R8 no strobe rgb", rgb_out, 12'h3C3);
    check("R8 no strobe mark", mark_out, 0);
    // R9
    rd(3'd7, v); check("R9 unused addr", v, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule